// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block controls one phase-locked loop. Software loads the requested reference divider, output divider and feedback multiplier through a small word-addressed register port, then writes a start command. From then on the hardware runs the reprogramming order by itself. It bypasses the PLL output and holds the PLL in reset. It applies the dividers and keeps reset asserted for a settle interval. It releases reset and waits for the lock input. Only after lock does it switch the output mux to the PLL. The dividers driven to the PLL cannot change while the PLL is running normally.

The lock input comes from the analog macro, so it passes through a two-flop synchronizer first. The synchronized value can be read back in the multiplier word. A lock timeout, enabled by a parameter, ends a sequence that never locks. In that case it raises an error flag and leaves the output in bypass. The output rate follows 24 MHz × (fb+1) / ((ref+1) × (out+1)), where each field holds its value minus one.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (slow), pll_rst_o is 1, all divider outputs are 0, and busy_o, done_o and err_o are 0.
- R2: The register port uses a word index on addr_i, with writes taking effect at the clock edge. Word 0 holds the reference divider in bits 13:8 and the output divider in bits 3:0. Word 1 holds the feedback multiplier in bits 12:0. Unused bits read as 0. Writing these words does not change the divider outputs.
- R3: Writing word 2 with bit 0 set while idle starts a sequence. At the capturing edge, busy_o rises, mode_o goes to 0 and pll_rst_o to 1 while the dividers keep their old values. The stored dividers reach the outputs one edge later.
- R4: pll_rst_o stays 1 for exactly SETTLE_US × CLK_MHZ cycles after the dividers are applied, and then falls.
- R5: After reset is released, mode_o stays 0 until the synchronized lock is seen. lock_i reaches the sequencer two edges after it changes. On the edge that follows, mode_o becomes 1 (normal), done_o pulses for one cycle and busy_o falls. Mode value 3 (deep slow) is never driven.
- R6: While busy, start commands are ignored and writes to words 0 and 1 leave the stored values unchanged. Outside a sequence, the divider outputs never change.
- R7: If lock is still absent LOCK_TIMEOUT_CYC cycles after reset is released, err_o rises and busy_o falls, with mode_o left at 0 and no done pulse. err_o clears at the next start.
- R8: Word 1 bit 31 reads the synchronized lock status.
- R9: Word 2 reads err in bit 1 and busy in bit 0. Word 3 reads mode in bits 9:8 and PLL reset in bit 5. Writes to word 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| lock_i | input | 1 | Lock indication from the PLL (asynchronous) |
| ref_div_o | output | 6 | Applied reference divider minus one |
| out_div_o | output | 4 | Applied output divider minus one |
| fb_mul_o | output | 13 | Applied feedback multiplier minus one |
| mode_o | output | 2 | Output mux select: 0 slow, 1 normal |
| pll_rst_o | output | 1 | PLL reset, active high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when normal mode is entered |
| err_o | output | 1 | Lock timeout occurred in the last sequence |

## Verification
The hardest cases to reach are the ones inside a running sequence: a divider rewrite or a second start that lands in the settle window, and a sequence that ends by timeout. The bench places both writes in the first cycles of the settle window. It then checks that reset still falls on exactly the same cycle and that the stored dividers read back unchanged. For the timeout case it holds lock low through the whole wait window, checks the cycle before and the cycle of expiry, and then confirms that the next start clears the error and finishes normally.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int REF_W = 6;
  localparam int OUT_W = 4;
  localparam int FB_W  = 13;

  localparam logic [1:0] MODE_SLOW   = 2'd0;
  localparam logic [1:0] MODE_NORMAL = 2'd1;

  localparam logic [1:0] W_DIV  = 2'd0;
  localparam logic [1:0] W_MUL  = 2'd1;
  localparam logic [1:0] W_CMD  = 2'd2;
  localparam logic [1:0] W_CTRL = 2'd3;

  typedef struct packed {
    logic [REF_W-1:0] ref_div;
    logic [OUT_W-1:0] out_div;
    logic [FB_W-1:0]  fb_mul;
  } div_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROG,
    ST_SETTLE,
    ST_LOCK
  } seq_state_e;
endpackage

// File: rtl/pll_seq_sync.sv
module pll_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pll_seq_regs.sv
module pll_seq_regs
  import pll_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  input  logic        busy_i,
  input  logic        err_i,
  input  logic        lock_i,
  input  logic [1:0]  mode_i,
  input  logic        pll_rst_i,
  output div_cfg_t    cfg_o,
  output logic        start_o,
  output logic [31:0] rdata_o
);
  div_cfg_t cfg_q;
  logic     unused_wdata;

  assign unused_wdata = ^wdata_i;

  // r6_: request words frozen while a sequence runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i && !busy_i) begin
      if (addr_i == W_DIV) begin
        cfg_q.ref_div <= wdata_i[13:8];
        cfg_q.out_div <= wdata_i[3:0];
      end
      if (addr_i == W_MUL) cfg_q.fb_mul <= wdata_i[12:0];
    end
  end

  assign start_o = we_i && (addr_i == W_CMD) && wdata_i[0] && !busy_i;
  assign cfg_o   = cfg_q;

  always_comb begin
    unique case (addr_i)
      W_DIV:   rdata_o = {18'd0, cfg_q.ref_div, 4'd0, cfg_q.out_div};
      W_MUL:   rdata_o = {lock_i, 18'd0, cfg_q.fb_mul};
      W_CMD:   rdata_o = {30'd0, err_i, busy_i};
      default: rdata_o = {22'd0, mode_i, 2'd0, pll_rst_i, 5'd0};
    endcase
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int SETTLE_CYC  = 1000,
  parameter int TIMEOUT_CYC = 4000,
  parameter bit TIMEOUT_EN  = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  div_cfg_t cfg_i,
  input  logic     lock_i,
  output div_cfg_t cfg_o,
  output logic [1:0] mode_o,
  output logic     pll_rst_o,
  output logic     busy_o,
  output logic     done_o,
  output logic     err_o
);
  localparam int MAX_CYC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tmo_hit;

  if (TIMEOUT_EN) begin : g_tmo
    assign tmo_hit = (cnt_q == TMO_LAST);
  end else begin : g_no_tmo
    assign tmo_hit = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cfg_o     <= '0;
      mode_o    <= MODE_SLOW;
      pll_rst_o <= 1'b1;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          // bypass and reset in the same step, before touching dividers
          mode_o    <= MODE_SLOW;
          pll_rst_o <= 1'b1;
          err_o     <= 1'b0;
          state_q   <= ST_PROG;
        end
        ST_PROG: begin
          cfg_o   <= cfg_i;
          cnt_q   <= '0;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_q == SETTLE_LAST) begin
            pll_rst_o <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_LOCK;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_LOCK: begin
          if (lock_i) begin
            mode_o  <= MODE_NORMAL;
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (tmo_hit) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int CLK_MHZ          = 100,
  parameter int SETTLE_US        = 10,
  parameter int LOCK_TIMEOUT_CYC = 4000,
  parameter bit LOCK_TIMEOUT_EN  = 1'b1,
  parameter int SYNC_STAGES      = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  output logic [31:0] rdata_o,
  input  logic        lock_i,
  output logic [5:0]  ref_div_o,
  output logic [3:0]  out_div_o,
  output logic [12:0] fb_mul_o,
  output logic [1:0]  mode_o,
  output logic        pll_rst_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;

  div_cfg_t req_cfg, app_cfg;
  logic     start, lock_s;

  pll_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lock_i),
    .q_o   (lock_s)
  );

  pll_seq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .busy_i   (busy_o),
    .err_i    (err_o),
    .lock_i   (lock_s),
    .mode_i   (mode_o),
    .pll_rst_i(pll_rst_o),
    .cfg_o    (req_cfg),
    .start_o  (start),
    .rdata_o  (rdata_o)
  );

  pll_seq_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .TIMEOUT_CYC(LOCK_TIMEOUT_CYC),
    .TIMEOUT_EN (LOCK_TIMEOUT_EN)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cfg_i    (req_cfg),
    .lock_i   (lock_s),
    .cfg_o    (app_cfg),
    .mode_o   (mode_o),
    .pll_rst_o(pll_rst_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  assign ref_div_o = app_cfg.ref_div;
  assign out_div_o = app_cfg.out_div;
  assign fb_mul_o  = app_cfg.fb_mul;
endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [5:0]  ref_div_o,
  input logic [3:0]  out_div_o,
  input logic [12:0] fb_mul_o,
  input logic [1:0]  mode_o,
  input logic        pll_rst_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  p_mode_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o inside {2'd0, 2'd1});

  p_done_normal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mode_o == 2'd1) && !busy_o && !pll_rst_o);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_rst_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> (mode_o == 2'd0));

  p_start_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> pll_rst_o && (mode_o == 2'd0));

  p_div_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable({ref_div_o, out_div_o, fb_mul_o}));

  p_err_no_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o && !busy_o && (mode_o == 2'd0));
endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ref_div_o(ref_div_o),
  .out_div_o(out_div_o),
  .fb_mul_o (fb_mul_o),
  .mode_o   (mode_o),
  .pll_rst_o(pll_rst_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .err_o    (err_o)
);

// File: tb/pll_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pll_seq_ctrl_bench;
  localparam int S_CYC = 1000;
  localparam int T_CYC = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic        lock_i = 1'b0;
  logic [5:0]  ref_div_o;
  logic [3:0]  out_div_o;
  logic [12:0] fb_mul_o;
  logic [1:0]  mode_o;
  logic        pll_rst_o, busy_o, done_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  pll_seq_ctrl u_pll_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .lock_i(lock_i), .ref_div_o(ref_div_o),
    .out_div_o(out_div_o), .fb_mul_o(fb_mul_o), .mode_o(mode_o),
    .pll_rst_o(pll_rst_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 mode", 32'(mode_o), 32'd0);
    chk("R1 pll_rst", 32'(pll_rst_o), 32'd1);
    chk("R1 dividers", {ref_div_o, out_div_o, fb_mul_o}, 32'd0);
    chk("R1 busy/done/err", {busy_o, done_o, err_o}, 32'd0);
    rd(2'd3, d);
    chk("R9 word3 after reset", d, 32'h20);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_CBF1);
    wr(2'd1, 32'hFFFF_E017);
    rd(2'd0, d);
    chk("R2 word0 readback", d, 32'h0000_0B01);
    rd(2'd1, d);
    chk("R2 word1 readback", d, 32'h0000_0017);
    chk("R2 outputs untouched", {ref_div_o, out_div_o, fb_mul_o}, 32'd0);
  endtask

  task automatic t_sequence();
    logic [31:0] d;
    wr(2'd2, 32'h1);
    chk("R3 busy at start", 32'(busy_o), 32'd1);
    chk("R3 slow+reset at start", {30'd0, mode_o == 2'd0, pll_rst_o}, 32'd3);
    chk("R3 dividers old at start", {ref_div_o, out_div_o, fb_mul_o}, 32'd0);
    rd(2'd2, d);
    chk("R9 word2 busy", d, 32'h1);
    step(1);
    chk("R3 ref applied", 32'(ref_div_o), 32'd11);
    chk("R3 out applied", 32'(out_div_o), 32'd1);
    chk("R3 fb applied", 32'(fb_mul_o), 32'd23);
    wr(2'd0, 32'h0000_3F0F);
    wr(2'd2, 32'h1);
    step(S_CYC - 3);
    chk("R4 reset held through settle", 32'(pll_rst_o), 32'd1);
    step(1);
    chk("R4 reset released", 32'(pll_rst_o), 32'd0);
    rd(2'd0, d);
    chk("R6 word0 write while busy ignored", d, 32'h0000_0B01);
    step(5);
    chk("R5 slow while unlocked", 32'(mode_o), 32'd0);
    chk("R5 still busy", 32'(busy_o), 32'd1);
    lock_i = 1'b1;
    step(2);
    chk("R5 sync delay", 32'(mode_o), 32'd0);
    step(1);
    chk("R5 normal after lock", 32'(mode_o), 32'd1);
    chk("R5 done pulse", 32'(done_o), 32'd1);
    chk("R6 busy cleared, no restart", 32'(busy_o), 32'd0);
    step(1);
    chk("R5 done one cycle", 32'(done_o), 32'd0);
    chk("R6 no second sequence", {30'd0, busy_o, pll_rst_o}, 32'd0);
    rd(2'd1, d);
    chk("R8 lock bit", d, 32'h8000_0017);
    rd(2'd3, d);
    chk("R9 word3 normal", d, 32'h100);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    lock_i = 1'b0;
    step(3);
    rd(2'd1, d);
    chk("R8 lock bit low", d, 32'h0000_0017);
    wr(2'd2, 32'h1);
    step(1);
    step(S_CYC);
    chk("R7 reset released", 32'(pll_rst_o), 32'd0);
    step(T_CYC - 1);
    chk("R7 no error before window", {30'd0, err_o, busy_o}, 32'd1);
    step(1);
    chk("R7 error raised", 32'(err_o), 32'd1);
    chk("R7 busy dropped", 32'(busy_o), 32'd0);
    chk("R7 mode slow", 32'(mode_o), 32'd0);
    chk("R7 no done", 32'(done_o), 32'd0);
    rd(2'd2, d);
    chk("R9 word2 err", d, 32'h2);
    wr(2'd3, 32'h0000_0100);
    chk("R9 word3 write ignored", 32'(mode_o), 32'd0);
    rd(2'd3, d);
    chk("R9 word3 readback", d, 32'h0);
    lock_i = 1'b1;
    step(3);
    wr(2'd2, 32'h1);
    chk("R7 err cleared on start", 32'(err_o), 32'd0);
    step(1);
    step(S_CYC);
    chk("R5 slow at release", 32'(mode_o), 32'd0);
    step(1);
    chk("R5 normal with lock held", {30'd0, mode_o}, 32'd1);
    chk("R5 done after retry", 32'(done_o), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_sequence();
    t_timeout();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule